// File: doc/BRIEF.md
# Security-Lock Configuration Register File

This block is a compact bank of configuration registers on a simple synchronous bus. The bus has an address, a write strobe, one byte of write data and one byte of registered read data. Early boot software uses the bank to switch off access to sensitive regions and to sequence a second processor. Several bits can change in one direction only:

- The boot ROM upper-half hide lock can only be set.
- The one-time-programmable key-area block can only be set.
- The secondary processor's boot ROM hide lock can only be set.
- The secondary processor's hold-in-reset bit can only be cleared.

Every register drives a dedicated control output. The consumers of those outputs (memories, the DMA engine, the secondary core) are outside the block.

The bank has two asynchronous active-low reset pins, and each is released synchronously to the clock.

- The cold reset returns every bit to its power-on value.
- The warm reset clears only the four-bit per-device DMA enable mask and the read register.
- The one-way bits and the 32-bit boot-environment word keep their values through a warm reset. Software writes tags such as 1, 3 or 7 into the boot-environment word to record which firmware ran before.

Top module: `secure_cfg_regs`

## Requirements
- R1: After a cold reset, all lock outputs are 0, `sec_hold_rst_o` is 1, `dma_en_o` is 0, `boot_env_o` is 0 and `rd_data` is 0.
- R2: Writing a byte with bit 0 set to offset 0x00 sets `rom_hide_o`. Once set, no write clears it before a cold reset.
- R3: Writing a byte with bit 1 set to offset 0x00 sets `otp_block_o`. Once set, no write clears it before a cold reset.
- R4: Writing a byte with bit 0 set to offset 0x01 sets `sec_rom_hide_o`. Once set, no write clears it before a cold reset.
- R5: `sec_hold_rst_o` is readable and writable at bit 0 of offset 0x02. Writing 0 clears it. After it has been cleared, writing 1 has no effect until a cold reset.
- R6: Offset 0x08 bits 3..0 hold the DMA enable mask `dma_en_o`, one bit per device, where 1 means enabled. Bits 7..4 are ignored on write and read as 0.
- R7: The boot-environment word `boot_env_o` is written and read one byte at a time. Offset 0x10000+k (k = 0..3) maps to bits 8k+7..8k.
- R8: A warm reset clears `dma_en_o`. It leaves `boot_env_o`, the three locks and `sec_hold_rst_o` unchanged.
- R9: A cold reset returns every register, including `boot_env_o`, to its R1 value.
- R10: Unused bits of a mapped register read 0 and ignore writes. Any unmapped offset reads 0, and writing to it changes no output.
- R11: `rd_data` is registered. It shows the byte at the address presented at the previous clock edge. A read at the edge that also writes the same register returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst_n | input | 1 | Asynchronous active-low warm reset |
| addr | input | 17 | Byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| rom_hide_o | output | 1 | Hides primary boot ROM upper half |
| otp_block_o | output | 1 | Blocks the OTP key area |
| sec_rom_hide_o | output | 1 | Hides secondary boot ROM upper half |
| sec_hold_rst_o | output | 1 | Holds the secondary processor in reset |
| dma_en_o | output | 4 | Per-device DMA request enables |
| boot_env_o | output | 32 | Boot-environment word |

## Verification
The checker assumes that the two reset pins stay low for at least one clock edge whenever they are asserted. It also assumes that `addr` and `wr_en` are stable around each rising edge. The stability properties are disabled while either reset pin is low. The bench changes inputs only on falling edges and holds each reset for several cycles. After each release it waits for the internal synchronizers to release before it issues any write, because writes during that window are dropped.

// File: rtl/secure_cfg_pkg.sv
package secure_cfg_pkg;
  localparam int OFF_PRIM = 32'h0000_0000;
  localparam int OFF_SEC  = 32'h0000_0001;
  localparam int OFF_HOLD = 32'h0000_0002;
  localparam int OFF_DMA  = 32'h0000_0008;
  localparam int OFF_ENV  = 32'h0001_0000;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIM,
    SEL_SEC,
    SEL_HOLD,
    SEL_DMA,
    SEL_ENV
  } reg_sel_e;
endpackage

// File: rtl/crf_rst_sync.sv
module crf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/crf_oneway_bit.sv
module crf_oneway_bit #(
  parameter bit SET_ONLY = 1'b1,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  output logic q
);
  logic q_q;
  logic q_nxt;

  generate
    if (SET_ONLY) begin : g_set
      always_comb q_nxt = q_q | (wr & wbit);
    end else begin : g_clr
      always_comb q_nxt = q_q & ~(wr & ~wbit);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= RST_VAL;
    else        q_q <= q_nxt;
  end

  assign q = q_q;
endmodule

// File: rtl/crf_field.sv
module crf_field #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_nxt;

  always_comb q_nxt = en ? d : q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_nxt;
  end

  assign q = q_q;
endmodule

// File: rtl/secure_cfg_regs.sv
module secure_cfg_regs
  import secure_cfg_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DMA_N     = 4,
  parameter int ENV_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   cold_rst_n,
  input  logic                   warm_rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr_en,
  input  logic [7:0]             wr_data,
  output logic [7:0]             rd_data,
  output logic                   rom_hide_o,
  output logic                   otp_block_o,
  output logic                   sec_rom_hide_o,
  output logic                   sec_hold_rst_o,
  output logic [DMA_N-1:0]       dma_en_o,
  output logic [ENV_BYTES*8-1:0] boot_env_o
);
  localparam int ENV_W  = ENV_BYTES * 8;
  localparam int LANE_W = (ENV_BYTES > 1) ? $clog2(ENV_BYTES) : 1;

  logic cold_rst_sync_n;
  logic warm_rst_sync_n;
  logic warm_arst_n;

  assign warm_arst_n = warm_rst_n & cold_rst_n;

  crf_rst_sync u_cold_sync (.clk(clk), .arst_n(cold_rst_n),  .rst_n_o(cold_rst_sync_n));
  crf_rst_sync u_warm_sync (.clk(clk), .arst_n(warm_arst_n), .rst_n_o(warm_rst_sync_n));

  // Address decode
  reg_sel_e          sel;
  logic [LANE_W-1:0] lane;

  always_comb begin
    sel  = SEL_NONE;
    lane = addr[LANE_W-1:0];
    if      (addr == ADDR_W'(OFF_PRIM)) sel = SEL_PRIM;
    else if (addr == ADDR_W'(OFF_SEC))  sel = SEL_SEC;
    else if (addr == ADDR_W'(OFF_HOLD)) sel = SEL_HOLD;
    else if (addr == ADDR_W'(OFF_DMA))  sel = SEL_DMA;
    else if ((addr >= ADDR_W'(OFF_ENV)) &&
             (addr <  ADDR_W'(OFF_ENV + ENV_BYTES))) sel = SEL_ENV;
  end

  logic wr_prim, wr_sec, wr_hold, wr_dma, wr_env;
  assign wr_prim = wr_en && (sel == SEL_PRIM);
  assign wr_sec  = wr_en && (sel == SEL_SEC);
  assign wr_hold = wr_en && (sel == SEL_HOLD);
  assign wr_dma  = wr_en && (sel == SEL_DMA);
  assign wr_env  = wr_en && (sel == SEL_ENV);

  // One-way bits, cleared only by cold reset
  crf_oneway_bit #(.SET_ONLY(1'b1), .RST_VAL(1'b0)) u_rom_hide (
    .clk(clk), .rst_n(cold_rst_sync_n), .wr(wr_prim), .wbit(wr_data[0]), .q(rom_hide_o));
  crf_oneway_bit #(.SET_ONLY(1'b1), .RST_VAL(1'b0)) u_otp_block (
    .clk(clk), .rst_n(cold_rst_sync_n), .wr(wr_prim), .wbit(wr_data[1]), .q(otp_block_o));
  crf_oneway_bit #(.SET_ONLY(1'b1), .RST_VAL(1'b0)) u_sec_rom_hide (
    .clk(clk), .rst_n(cold_rst_sync_n), .wr(wr_sec), .wbit(wr_data[0]), .q(sec_rom_hide_o));
  crf_oneway_bit #(.SET_ONLY(1'b0), .RST_VAL(1'b1)) u_sec_hold (
    .clk(clk), .rst_n(cold_rst_sync_n), .wr(wr_hold), .wbit(wr_data[0]), .q(sec_hold_rst_o));

  // DMA enable mask, warm domain
  crf_field #(.W(DMA_N)) u_dma (
    .clk(clk), .rst_n(warm_rst_sync_n), .en(wr_dma), .d(wr_data[DMA_N-1:0]), .q(dma_en_o));

  // Boot-environment word, byte lanes, cold domain
  generate
    for (genvar g = 0; g < ENV_BYTES; g++) begin : g_env
      logic lane_en;
      assign lane_en = wr_env && (lane == LANE_W'(g));
      crf_field #(.W(8)) u_lane (
        .clk(clk), .rst_n(cold_rst_sync_n), .en(lane_en), .d(wr_data),
        .q(boot_env_o[g*8 +: 8]));
    end
  endgenerate

  // Registered read path
  logic [7:0] rd_nxt;
  logic [7:0] rd_q;

  always_comb begin
    rd_nxt = '0;
    unique case (sel)
      SEL_PRIM: rd_nxt = {6'b0, otp_block_o, rom_hide_o};
      SEL_SEC:  rd_nxt = {7'b0, sec_rom_hide_o};
      SEL_HOLD: rd_nxt = {7'b0, sec_hold_rst_o};
      SEL_DMA:  rd_nxt = 8'(dma_en_o);
      SEL_ENV:  rd_nxt = boot_env_o[8*lane +: 8];
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge warm_rst_sync_n) begin
    if (!warm_rst_sync_n) rd_q <= '0;
    else                  rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;

  logic unused_env_w;
  assign unused_env_w = ^ENV_W;
endmodule

// File: rtl/secure_cfg_regs_chk.sv
module secure_cfg_regs_chk
  import secure_cfg_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DMA_N     = 4,
  parameter int ENV_BYTES = 4
) (
  input logic                   clk,
  input logic                   cold_rst_n,
  input logic                   warm_rst_n,
  input logic [ADDR_W-1:0]      addr,
  input logic                   wr_en,
  input logic [7:0]             rd_data,
  input logic                   rom_hide_o,
  input logic                   otp_block_o,
  input logic                   sec_rom_hide_o,
  input logic                   sec_hold_rst_o,
  input logic [DMA_N-1:0]       dma_en_o,
  input logic [ENV_BYTES*8-1:0] boot_env_o
);
  logic env_hit, mapped;
  assign env_hit = (addr >= ADDR_W'(OFF_ENV)) && (addr < ADDR_W'(OFF_ENV + ENV_BYTES));
  assign mapped  = env_hit || addr == ADDR_W'(OFF_PRIM) || addr == ADDR_W'(OFF_SEC) ||
                   addr == ADDR_W'(OFF_HOLD) || addr == ADDR_W'(OFF_DMA);

  // R2
  rom_hide_sticky_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    rom_hide_o |=> rom_hide_o);
  // R3
  otp_block_sticky_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    otp_block_o |=> otp_block_o);
  // R4
  sec_rom_sticky_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    sec_rom_hide_o |=> sec_rom_hide_o);
  // R5
  hold_release_final_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !sec_hold_rst_o |=> !sec_hold_rst_o);
  // R6
  dma_only_by_write_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    !(wr_en && addr == ADDR_W'(OFF_DMA)) |=> $stable(dma_en_o));
  // R7
  env_only_by_write_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !(wr_en && env_hit) |=> $stable(boot_env_o));
  // R10
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    !mapped |=> rd_data == 8'h00);
  // R6
  dma_reserved_zero_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    addr == ADDR_W'(OFF_DMA) |=> rd_data[7:DMA_N] == '0);
  // R10
  prim_reserved_zero_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    addr == ADDR_W'(OFF_PRIM) |=> rd_data[7:2] == 6'b0);
endmodule

bind secure_cfg_regs secure_cfg_regs_chk #(
  .ADDR_W(ADDR_W), .DMA_N(DMA_N), .ENV_BYTES(ENV_BYTES)
) u_chk (.*);

// File: tb/tb_secure_cfg_regs.sv
module tb_secure_cfg_regs;
  localparam int ADDR_W = 17;
  localparam int NVEC   = 14;

  logic              clk = 1'b0;
  logic              cold_rst_n = 1'b0;
  logic              warm_rst_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_data = '0;
  logic [7:0]        rd_data;
  logic              rom_hide_o, otp_block_o, sec_rom_hide_o, sec_hold_rst_o;
  logic [3:0]        dma_en_o;
  logic [31:0]       boot_env_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  secure_cfg_regs dut (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rom_hide_o(rom_hide_o), .otp_block_o(otp_block_o),
    .sec_rom_hide_o(sec_rom_hide_o), .sec_hold_rst_o(sec_hold_rst_o),
    .dma_en_o(dma_en_o), .boot_env_o(boot_env_o));

  // {offset, write byte, expected read-back}
  localparam logic [ADDR_W+15:0] VEC [NVEC] = '{
    {17'h00008, 8'hFF, 8'h0F},  // R6 reserved high bits dropped
    {17'h00008, 8'h05, 8'h05},  // R6
    {17'h00000, 8'h01, 8'h01},  // R2
    {17'h00000, 8'h00, 8'h01},  // R2 cannot clear
    {17'h00000, 8'hFE, 8'h03},  // R3 and R10
    {17'h00001, 8'h00, 8'h00},  // R4 zero write
    {17'h00002, 8'h01, 8'h01},  // R5 still held
    {17'h00002, 8'h00, 8'h00},  // R5 release
    {17'h00002, 8'h01, 8'h00},  // R5 cannot re-hold
    {17'h10000, 8'h07, 8'h07},  // R7 lane 0
    {17'h10003, 8'hA5, 8'hA5},  // R7 lane 3
    {17'h00009, 8'hFF, 8'h00},  // R10 unmapped
    {17'h00040, 8'hFF, 8'h00},  // R10 unmapped
    {17'h00001, 8'h01, 8'h01}   // R4 set
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    step(3);
    cold_rst_n = 1'b1;
    step(3);
    // R1
    check("R1 rom_hide", 32'(rom_hide_o), 0);
    check("R1 otp_block", 32'(otp_block_o), 0);
    check("R1 sec_rom_hide", 32'(sec_rom_hide_o), 0);
    check("R1 sec_hold", 32'(sec_hold_rst_o), 1);
    check("R1 dma", 32'(dma_en_o), 0);
    check("R1 boot_env", boot_env_o, 0);
    check("R1 rd_data", 32'(rd_data), 0);

    for (int i = 0; i < NVEC; i++) begin
      write_byte(VEC[i][ADDR_W+15:16], VEC[i][15:8]);
      step(1);
      check($sformatf("vector %0d", i), 32'(rd_data), 32'(VEC[i][7:0]));
    end

    check("R2 output", 32'(rom_hide_o), 1);
    check("R3 output", 32'(otp_block_o), 1);
    check("R4 output", 32'(sec_rom_hide_o), 1);
    check("R5 output", 32'(sec_hold_rst_o), 0);
    check("R6 output", 32'(dma_en_o), 32'h5);
    check("R7 word", boot_env_o, 32'hA500_0007);
    // R10: the unmapped writes above left the DMA mask and boot word as they were
    check("R10 no side effect", {dma_en_o, boot_env_o[27:0]}, {4'h5, 28'h500_0007});

    // R11: old value at the write edge, new value one edge later
    write_byte(17'h00008, 8'h0A);
    check("R11 old value", 32'(rd_data), 32'h05);
    step(1);
    check("R11 new value", 32'(rd_data), 32'h0A);

    // R8 warm reset
    warm_rst_n = 1'b0;
    step(2);
    warm_rst_n = 1'b1;
    step(3);
    check("R8 dma cleared", 32'(dma_en_o), 0);
    check("R8 boot_env kept", boot_env_o, 32'hA500_0007);
    check("R8 locks kept", {rom_hide_o, otp_block_o, sec_rom_hide_o, sec_hold_rst_o}, 4'b1110);
    // R8: after a warm reset the one-way bits still refuse to change
    write_byte(17'h00002, 8'h01);
    step(1);
    check("R8 hold still released", 32'(rd_data), 0);
    write_byte(17'h00000, 8'h00);
    step(1);
    check("R8 prim locks read", 32'(rd_data), 32'h03);

    // R9 cold reset
    cold_rst_n = 1'b0;
    step(2);
    cold_rst_n = 1'b1;
    step(3);
    check("R9 word", boot_env_o, 0);
    check("R9 locks", {rom_hide_o, otp_block_o, sec_rom_hide_o, sec_hold_rst_o}, 4'b0001);
    check("R9 dma", 32'(dma_en_o), 0);
    addr = 17'h10003;
    step(1);
    check("R9 read", 32'(rd_data), 0);

    done = 1'b1;
  end

  initial begin : watchdog
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule